// File: doc/BRIEF.md
# Priority-Aware Hashed Flow Cache

This block is the flow table of an L4 offload datapath. Each entry stands for one TCP or UDP flow, identified by its IPv4 5-tuple. The entry sits in exactly one slot, chosen by a hash of that tuple. The control processor installs and removes flows through a single command port. It does this after connection setup. From then on, the packet path queries the table through a separate lookup port. For every packet it learns whether the flow is cached and which slot holds it, so cached flows need no processor work.

Every lookup hit adds the packet length to the slot's byte count. The byte count sets a two-bit priority, so a flow that has moved more data ranks higher. When an install lands on a slot held by another flow, a mode input selects the arbitration. In baseline mode the newcomer always wins. In prioritized mode the resident flow is kept if it is heavy, unless it has gone idle for longer than an aging limit. In that case the rejected flow stays on the processor path.

The 104-bit key is laid out as {source address [103:72], destination address [71:40], source port [39:24], destination port [23:8], protocol [7:0]}. The layout matters only through the hash. Depth is a parameter and is verified at 64 slots.

Top module: `flow_cache_prio`

## Requirements
- R1: The slot of a key is the low log2(DEPTH) bits of its CRC-32. The CRC uses the reflected polynomial 0xEDB88320 and an all-ones start value, takes key bit 0 first, and inverts the result at the end. Both response ports report this slot, on a hit and on a miss alike.
- R2: A lookup presented with lk_valid before clock edge k sets lk_rsp_valid for exactly the cycle after edge k+1. lk_rsp_hit is 1 only when the slot is occupied by the identical key.
- R3: Each lookup hit adds lk_len to the 32-bit byte count of that slot. The count saturates at all ones.
- R4: The priority of a slot is 0 below 4096 bytes, 1 below 65536 bytes, 2 below 1048576 bytes, and 3 above that. It takes its new value one cycle after the count changes.
- R5: An install into an empty slot answers code 0 (accepted). It stores the key with a count of zero and priority 0.
- R6: An install of a key that already holds its slot answers code 0. It keeps the slot's count and priority, and only restarts the slot's idle time.
- R7: In prioritized mode (prio_mode=1), an install onto a slot held by a different key answers code 2 (replaced) and takes the slot in two cases: the resident priority is 0, or at least AGE_LIMIT cycles have passed since the resident's last install or hit. Otherwise the install answers code 1 (rejected) and leaves the resident unchanged.
- R8: In baseline mode (prio_mode=0), a colliding install always answers code 2 and takes the slot, whatever the resident count.
- R9: A remove whose key matches the resident answers code 3 and empties the slot. A remove of any other key answers code 1 and changes nothing.
- R10: Every command (cmd_op 0 = install, 1 = remove) sets cmd_rsp_valid, code and slot in the cycle after the edge that takes it.
- R11: A lookup and a command in the same cycle on the same slot work as follows. The lookup reports the contents from before the command. A hit on a flow that has been displaced by then adds nothing to the new occupant's count.
- R12: After reset every slot is empty, and both response valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prio_mode | input | 1 | 1 = size-priority arbitration, 0 = newcomer always wins |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | 104 | Flow 5-tuple to look up |
| lk_len | input | 16 | Packet length in bytes, added on a hit |
| lk_rsp_valid | output | 1 | Lookup result valid |
| lk_rsp_hit | output | 1 | Flow found |
| lk_rsp_idx | output | 6 | Slot of the looked-up key |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 1 | 0 = install, 1 = remove |
| cmd_key | input | 104 | Flow 5-tuple of the command |
| cmd_rsp_valid | output | 1 | Command result valid |
| cmd_rsp_code | output | 2 | 0 accepted, 1 rejected, 2 replaced, 3 removed |
| cmd_rsp_idx | output | 6 | Slot the command addressed |

## Verification
A lookup of a light resident flow can fall in the same cycle as an install of a colliding key that evicts it. The bench drives both in one cycle with a lookup length large enough to lift a flow out of priority 0. It then expects two things: the lookup reports a hit, and a later colliding install replaces the new occupant. That replacement shows the bytes were not credited to the wrong flow. Random mixes of lookups, installs and removes over two small groups of colliding keys are compared against a slot model held in the bench.

// File: rtl/flow_cache_prio.sv
module flow_cache_prio #(
  parameter int DEPTH      = 64,
  parameter int KEY_W      = 104,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 32,
  parameter int TS_W       = 16,
  parameter int AGE_LIMIT  = 2048,
  parameter int LVL1_BYTES = 4096,
  parameter int LVL2_BYTES = 65536,
  parameter int LVL3_BYTES = 1048576,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prio_mode,
  input  logic             lk_valid,
  input  logic [KEY_W-1:0] lk_key,
  input  logic [LEN_W-1:0] lk_len,
  output logic             lk_rsp_valid,
  output logic             lk_rsp_hit,
  output logic [IDX_W-1:0] lk_rsp_idx,
  input  logic             cmd_valid,
  input  logic             cmd_op,
  input  logic [KEY_W-1:0] cmd_key,
  output logic             cmd_rsp_valid,
  output logic [1:0]       cmd_rsp_code,
  output logic [IDX_W-1:0] cmd_rsp_idx
);
  localparam logic [1:0] CODE_ACC = 2'd0;
  localparam logic [1:0] CODE_REJ = 2'd1;
  localparam logic [1:0] CODE_RPL = 2'd2;
  localparam logic [1:0] CODE_RMV = 2'd3;

  function automatic logic [IDX_W-1:0] slot_of(input logic [KEY_W-1:0] k);
    logic [31:0] c;
    c = '1;
    for (int i = 0; i < KEY_W; i++) begin
      if (c[0] ^ k[i]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    c = ~c;
    return c[IDX_W-1:0];
  endfunction

  function automatic logic [1:0] level_of(input logic [CNT_W-1:0] b);
    if (b < CNT_W'(LVL1_BYTES)) return 2'd0;
    if (b < CNT_W'(LVL2_BYTES)) return 2'd1;
    if (b < CNT_W'(LVL3_BYTES)) return 2'd2;
    return 2'd3;
  endfunction

  logic [DEPTH-1:0] vld;
  logic [KEY_W-1:0] keys  [DEPTH];
  logic [CNT_W-1:0] cnt   [DEPTH];
  logic [1:0]       lvl   [DEPTH];
  logic [TS_W-1:0]  stamp [DEPTH];
  logic [TS_W-1:0]  now;

  logic             s1_v, s1_hit;
  logic [IDX_W-1:0] s1_idx;
  logic [KEY_W-1:0] s1_key;
  logic [LEN_W-1:0] s1_len;
  logic             upd_v;
  logic [IDX_W-1:0] upd_idx;

  wire [IDX_W-1:0] lk_slot = slot_of(lk_key);
  wire [IDX_W-1:0] c_slot  = slot_of(cmd_key);
  wire             c_occ   = vld[c_slot];
  wire             c_same  = c_occ && (keys[c_slot] == cmd_key);
  wire [TS_W-1:0]  c_idle  = now - stamp[c_slot];
  wire             c_aged  = c_idle >= TS_W'(AGE_LIMIT);
  wire             c_evict = !prio_mode || (lvl[c_slot] == 2'd0) || c_aged;

  logic [1:0] c_code;
  always_comb begin
    if (cmd_op)       c_code = c_same ? CODE_RMV : CODE_REJ;
    else if (!c_occ)  c_code = CODE_ACC;
    else if (c_same)  c_code = CODE_ACC;
    else if (c_evict) c_code = CODE_RPL;
    else              c_code = CODE_REJ;
  end

  wire             c_fresh  = cmd_valid && !cmd_op &&
                              ((c_code == CODE_RPL) || (c_code == CODE_ACC && !c_occ));
  wire             c_touch  = cmd_valid && !cmd_op && c_same;
  wire             s1_still = vld[s1_idx] && (keys[s1_idx] == s1_key);
  wire             bump     = s1_v && s1_hit && s1_still;
  wire [CNT_W:0]   sum_w    = {1'b0, cnt[s1_idx]} + (CNT_W+1)'(s1_len);
  wire [CNT_W-1:0] sum_sat  = sum_w[CNT_W] ? '1 : sum_w[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld           <= '0;
      now           <= '0;
      s1_v          <= 1'b0;
      s1_hit        <= 1'b0;
      s1_idx        <= '0;
      s1_key        <= '0;
      s1_len        <= '0;
      upd_v         <= 1'b0;
      upd_idx       <= '0;
      lk_rsp_valid  <= 1'b0;
      lk_rsp_hit    <= 1'b0;
      lk_rsp_idx    <= '0;
      cmd_rsp_valid <= 1'b0;
      cmd_rsp_code  <= CODE_ACC;
      cmd_rsp_idx   <= '0;
    end else begin
      now           <= now + 1'b1;
      s1_v          <= lk_valid;
      s1_hit        <= vld[lk_slot] && (keys[lk_slot] == lk_key);
      s1_idx        <= lk_slot;
      s1_key        <= lk_key;
      s1_len        <= lk_len;
      lk_rsp_valid  <= s1_v;
      lk_rsp_hit    <= s1_v && s1_hit;
      lk_rsp_idx    <= s1_idx;
      upd_v         <= bump;
      upd_idx       <= s1_idx;
      cmd_rsp_valid <= cmd_valid;
      cmd_rsp_code  <= c_code;
      cmd_rsp_idx   <= c_slot;
      if (cmd_valid && cmd_op && c_code == CODE_RMV) vld[c_slot] <= 1'b0;
      if (c_fresh) vld[c_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_v) lvl[upd_idx] <= level_of(cnt[upd_idx]);
    if (bump) begin
      cnt[s1_idx]   <= sum_sat;
      stamp[s1_idx] <= now;
    end
    if (c_fresh) begin
      keys[c_slot]  <= cmd_key;
      cnt[c_slot]   <= '0;
      lvl[c_slot]   <= 2'd0;
      stamp[c_slot] <= now;
    end else if (c_touch) begin
      stamp[c_slot] <= now;
    end
  end

  assert_lk_two_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ##2 lk_rsp_valid);

  assert_cmd_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> cmd_rsp_valid);

  assert_install_occupies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_op |=> vld[$past(c_slot)]);

  assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_op && c_code == CODE_REJ |=> keys[$past(c_slot)] == $past(keys[c_slot]));

  assert_baseline_no_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_op && !prio_mode |=> cmd_rsp_code != CODE_REJ);

  assert_remove_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op && vld[c_slot] && keys[c_slot] == cmd_key |=> !vld[$past(c_slot)]);
endmodule

// File: tb/flow_cache_prio_test.sv
module flow_cache_prio_test;
  localparam int AGE = 2048;

  logic         clk = 1'b0, rst_n = 1'b0, prio_mode = 1'b1;
  logic         lk_valid = 1'b0, cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [103:0] lk_key = '0, cmd_key = '0;
  logic [15:0]  lk_len = '0;
  logic         lk_rsp_valid, lk_rsp_hit, cmd_rsp_valid;
  logic [5:0]   lk_rsp_idx, cmd_rsp_idx;
  logic [1:0]   cmd_rsp_code;

  flow_cache_prio uut (
    .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode),
    .lk_valid(lk_valid), .lk_key(lk_key), .lk_len(lk_len),
    .lk_rsp_valid(lk_rsp_valid), .lk_rsp_hit(lk_rsp_hit), .lk_rsp_idx(lk_rsp_idx),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_key(cmd_key),
    .cmd_rsp_valid(cmd_rsp_valid), .cmd_rsp_code(cmd_rsp_code), .cmd_rsp_idx(cmd_rsp_idx)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_slot(input logic [103:0] k);
    logic [31:0] c, r;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 104; i++) begin
      logic fb;
      fb = c[31] ^ k[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    for (int j = 0; j < 32; j++) r[j] = c[31-j];
    r = ~r;
    return r[5:0];
  endfunction

  function automatic int ref_level(input longint b);
    if (b < 4096) return 0;
    if (b < 65536) return 1;
    if (b < 1048576) return 2;
    return 3;
  endfunction

  task automatic rand_key(output logic [103:0] k);
    k = {$urandom(), $urandom(), $urandom(), 8'($urandom())};
  endtask

  task automatic key_at(input logic [5:0] s, output logic [103:0] k);
    do rand_key(k); while (ref_slot(k) != s);
  endtask

  task automatic lookup(input logic [103:0] k, input int len, output logic hit, output logic [5:0] idx);
    lk_valid = 1'b1; lk_key = k; lk_len = 16'(len);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R2 no response after one cycle", lk_rsp_valid, 0);
    @(negedge clk);
    chk("R2 response after two cycles", lk_rsp_valid, 1);
    hit = lk_rsp_hit; idx = lk_rsp_idx;
    @(negedge clk);
  endtask

  task automatic command(input logic op, input logic [103:0] k, output logic [1:0] code, output logic [5:0] idx);
    cmd_valid = 1'b1; cmd_op = op; cmd_key = k;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 command response after one cycle", cmd_rsp_valid, 1);
    code = cmd_rsp_code; idx = cmd_rsp_idx;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  logic         mv [64];
  logic [103:0] mk [64];
  longint       mc [64];

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [103:0] ka, kb, kc, kd, ke, kf, kx;
    logic [103:0] pool [8];
    logic [1:0] code;
    logic [5:0] idx, sa, sc, se;
    logic hit;
    void'($urandom(32'd20240611));

    @(negedge clk);
    chk("R12 lookup valid low in reset", lk_rsp_valid, 0);
    chk("R12 command valid low in reset", cmd_rsp_valid, 0);
    do_reset();
    chk("R12 lookup valid low after reset", lk_rsp_valid, 0);

    rand_key(ka); sa = ref_slot(ka);
    key_at(sa, kb);
    do sc = 6'($urandom()); while (sc == sa);
    do se = 6'($urandom()); while (se == sa || se == sc);
    key_at(sc, kc); key_at(sc, kd); key_at(se, ke); key_at(se, kf);
    rand_key(kx);

    lookup(ka, 10, hit, idx);
    chk("R12 empty table misses", hit, 0);
    command(1'b0, ka, code, idx);
    chk("R5 install into empty slot accepted", code, 0);
    chk("R1 install reports hashed slot", idx, sa);
    lookup(ka, 100, hit, idx);
    chk("R2 installed key hits", hit, 1);
    chk("R1 lookup reports hashed slot", idx, sa);
    lookup(kx, 100, hit, idx);
    chk("R2 unknown key misses", hit, (ref_slot(kx) == sa) ? 0 : 0);
    chk("R1 miss reports hashed slot", idx, ref_slot(kx));

    lookup(ka, 3995, hit, idx);
    command(1'b0, kb, code, idx);
    chk("R7 R3 resident at 4095 bytes still priority 0, replaced", code, 2);
    lookup(ka, 5, hit, idx);
    chk("R7 evicted flow misses", hit, 0);

    lookup(kb, 4096, hit, idx);
    chk("R3 resident hit", hit, 1);
    command(1'b0, ka, code, idx);
    chk("R4 R7 resident at 4096 bytes rejects newcomer", code, 1);
    lookup(kb, 1, hit, idx);
    chk("R7 rejected install leaves resident", hit, 1);

    command(1'b0, kb, code, idx);
    chk("R6 reinstall of resident accepted", code, 0);
    command(1'b0, ka, code, idx);
    chk("R6 refresh keeps priority", code, 1);

    command(1'b1, ka, code, idx);
    chk("R9 mismatched remove rejected", code, 1);
    lookup(kb, 1, hit, idx);
    chk("R9 mismatched remove leaves resident", hit, 1);
    command(1'b1, kb, code, idx);
    chk("R9 matching remove", code, 3);
    lookup(kb, 1, hit, idx);
    chk("R9 removed flow misses", hit, 0);

    command(1'b0, kb, code, idx);
    chk("R5 install after remove accepted", code, 0);
    lookup(kb, 60000, hit, idx);
    prio_mode = 1'b0;
    command(1'b0, ka, code, idx);
    chk("R8 baseline mode replaces heavy resident", code, 2);
    prio_mode = 1'b1;
    lookup(ka, 1, hit, idx);
    chk("R8 newcomer now resident", hit, 1);

    command(1'b0, kc, code, idx);
    chk("R5 second slot install", code, 0);
    lk_valid = 1'b1; lk_key = kc; lk_len = 16'd9000;
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_key = kd;
    @(negedge clk);
    lk_valid = 1'b0; cmd_valid = 1'b0;
    chk("R11 same-cycle install replaces light resident", cmd_rsp_code, 2);
    @(negedge clk);
    chk("R11 same-cycle lookup sees old resident", lk_rsp_hit, 1);
    @(negedge clk);
    @(negedge clk);
    command(1'b0, kc, code, idx);
    chk("R11 displaced hit did not credit new occupant", code, 2);

    command(1'b0, ke, code, idx);
    lookup(ke, 5000, hit, idx);
    command(1'b0, kf, code, idx);
    chk("R7 busy heavy resident rejects", code, 1);
    repeat (AGE + 10) @(negedge clk);
    command(1'b0, kf, code, idx);
    chk("R7 idle heavy resident replaced after aging", code, 2);

    do_reset();
    lookup(ka, 1, hit, idx);
    chk("R12 reset empties table", hit, 0);
    for (int i = 0; i < 4; i++) key_at(6'd5, pool[i]);
    for (int i = 4; i < 8; i++) key_at(6'd40, pool[i]);
    for (int i = 0; i < 64; i++) begin mv[i] = 1'b0; mk[i] = '0; mc[i] = 0; end
    for (int n = 0; n < 300; n++) begin
      int r, len;
      logic [103:0] k;
      logic [5:0] s;
      logic [1:0] ex;
      r = int'($urandom() % 100);
      k = pool[$urandom() % 8];
      s = ref_slot(k);
      if (r < 50) begin
        len = int'($urandom() % 3000);
        lookup(k, len, hit, idx);
        chk("R2 random lookup hit", hit, mv[s] && mk[s] == k);
        chk("R1 random lookup slot", idx, s);
        if (mv[s] && mk[s] == k) mc[s] += len;
      end else if (r < 85) begin
        if (!mv[s]) begin ex = 0; mv[s] = 1'b1; mk[s] = k; mc[s] = 0; end
        else if (mk[s] == k) ex = 0;
        else if (ref_level(mc[s]) == 0) begin ex = 2; mk[s] = k; mc[s] = 0; end
        else ex = 1;
        command(1'b0, k, code, idx);
        chk("R7 random install code", code, ex);
        chk("R1 random install slot", idx, s);
      end else begin
        ex = (mv[s] && mk[s] == k) ? 2'd3 : 2'd1;
        if (ex == 2'd3) mv[s] = 1'b0;
        command(1'b1, k, code, idx);
        chk("R9 random remove code", code, ex);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule